// File: doc/BRIEF.md
# I2C Controller Stop-Condition Sequencer

This block finishes a transfer on an I2C bus from the controller side by producing a stop condition. A one-cycle request starts the sequence. The block first pulls the data line low. It then lets go of the clock line that the controller had been holding low between bytes. A target may still be stretching that clock, so the block waits until it sees the clock actually high. From that point it counts a setup interval whose length depends on the selected speed mode. When the interval ends, it lets the data line rise, which forms the stop condition while the clock stays high.

Both bus lines are open-drain. The block only produces low-drive enables. It reads the resolved line levels back through a two-flop synchroniser. A one-cycle done pulse reports that the data line has really been observed high. The setup interval is expressed in nanoseconds for each mode and converted to clock cycles from the system clock frequency, always rounding up.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, and whenever idle, all four outputs are 0. A `stop_req` accepted in idle sets both `sda_drive_low` and `scl_drive_low` to 1 in the next cycle.
- R2: One cycle after R1, `scl_drive_low` returns to 0 and `wait_released` rises to 1, while `sda_drive_low` stays 1. `sda_drive_low` is 1 in every cycle in which `scl_drive_low` is 1.
- R3: While the `scl_in` line is held low by another device, `sda_drive_low` stays 1 with no time limit.
- R4: `sda_drive_low` falls at the (L+3)-th rising clock edge, counted from the first edge that samples `scl_in` high. L is the setup count for the latched mode: ceil(CLK_FREQ_KHZ*4000/10^6) cycles when `fast_mode`=0 (standard) and ceil(CLK_FREQ_KHZ*600/10^6) cycles when `fast_mode`=1 (fast). L is never less than 1.
- R5: If `scl_in` is seen low again during the setup interval, timing restarts. The rule of R4 then applies from the first edge that samples it high again.
- R6: `fast_mode` is captured when a request is accepted. Later changes to it have no effect on the sequence in progress.
- R7: `done` is high for exactly one cycle, starting after the third rising edge that samples `sda_in` high once `sda_drive_low` has fallen. `wait_released` returns to 0 in that same cycle. While `sda_in` stays low, `done` does not rise.
- R8: A `stop_req` that arrives while a sequence is in progress is ignored. `scl_drive_low` is not re-asserted and the timing of R4 is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to generate a stop condition |
| fast_mode | input | 1 | Speed mode select: 0 standard, 1 fast |
| scl_in | input | 1 | Resolved level of the bus clock line |
| sda_in | input | 1 | Resolved level of the bus data line |
| scl_drive_low | output | 1 | Pull the clock line low |
| sda_drive_low | output | 1 | Pull the data line low |
| wait_released | output | 1 | Controller clock hold has been let go; stop in progress |
| done | output | 1 | One-cycle pulse when the stop condition has completed |

## Verification
The assertions check several properties on every cycle:
- the data line is held low whenever the block grabs the clock;
- the data line never rises unless the synchronised clock was high the cycle before;
- the consecutive clock-high span before the data rise is at least the latched setup count;
- the mode stays fixed during a sequence, busy requests never re-grab the clock, and `done` lasts one cycle.

Only the bench scenarios can show the exact latencies. These are the L+3 edge count under each mode with several stretch lengths, the restart after a clock glitch, and the three-edge delay to `done` when another device keeps the data line low.

// File: rtl/stop_seq_pkg.sv
package stop_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GRAB,
        SQ_WAIT_SCL,
        SQ_SETUP,
        SQ_LET_SDA
    } sq_state_e;

    typedef struct packed {
        sq_state_e state;
        logic      fast;
        logic      done;
    } sq_regs_t;

    // Round-up conversion of a duration in ns to clock cycles, minimum 1.
    function automatic int ns_to_cycles(input int unsigned khz, input int unsigned ns);
        longint prod;
        longint cyc;
        prod = longint'(khz) * longint'(ns);
        cyc  = (prod + 64'd999_999) / 64'd1_000_000;
        return (cyc < 1) ? 1 : int'(cyc);
    endfunction

endpackage

// File: rtl/stop_line_sync.sv
module stop_line_sync #(
    parameter int NUM    = 2,
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NUM-1:0] lines_i,
    output logic [NUM-1:0] lines_o
);

    genvar g;
    generate
        for (g = 0; g < NUM; g++) begin : g_line
            logic [STAGES-1:0] pipe_d;
            logic [STAGES-1:0] pipe_q;

            always_comb begin
                pipe_d = {pipe_q[STAGES-2:0], lines_i[g]};
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '1;
                end else begin
                    pipe_q <= pipe_d;
                end
            end

            assign lines_o[g] = pipe_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/stop_setup_timer.sv
module stop_setup_timer #(
    parameter int STD_CYC  = 1000,
    parameter int FAST_CYC = 150,
    parameter int CNT_W    = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fast_i,
    output logic last_o
);

    localparam logic [CNT_W-1:0] STD_LAST  = CNT_W'(STD_CYC - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(FAST_CYC - 1);
    localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] limit;

    always_comb begin
        limit  = fast_i ? FAST_LAST : STD_LAST;
        cnt_d  = run_i ? (cnt_q + ONE) : '0;
        last_o = run_i && (cnt_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
    import stop_seq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_KHZ  = 250000,
    parameter int unsigned STD_SETUP_NS  = 4000,
    parameter int unsigned FAST_SETUP_NS = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_req,
    input  logic fast_mode,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_drive_low,
    output logic sda_drive_low,
    output logic wait_released,
    output logic done
);

    localparam int STD_CYC  = ns_to_cycles(CLK_FREQ_KHZ, STD_SETUP_NS);
    localparam int FAST_CYC = ns_to_cycles(CLK_FREQ_KHZ, FAST_SETUP_NS);
    localparam int MAX_CYC  = (STD_CYC > FAST_CYC) ? STD_CYC : FAST_CYC;
    localparam int CNT_W    = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC + 1);

    logic [1:0] lines_s;
    logic       scl_s;
    logic       sda_s;
    logic       tmr_last;

    sq_regs_t r_d;
    sq_regs_t r_q;

    stop_line_sync #(
        .NUM    (2),
        .STAGES (2)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .lines_i ({sda_in, scl_in}),
        .lines_o (lines_s)
    );

    assign scl_s = lines_s[0];
    assign sda_s = lines_s[1];

    stop_setup_timer #(
        .STD_CYC  (STD_CYC),
        .FAST_CYC (FAST_CYC),
        .CNT_W    (CNT_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  ((r_q.state == SQ_SETUP) && scl_s),
        .fast_i (r_q.fast),
        .last_o (tmr_last)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.state)
            SQ_IDLE: begin
                if (stop_req) begin
                    r_d.state = SQ_GRAB;
                    r_d.fast  = fast_mode;
                end
            end
            SQ_GRAB: begin
                r_d.state = SQ_WAIT_SCL;
            end
            SQ_WAIT_SCL: begin
                if (scl_s) begin
                    r_d.state = SQ_SETUP;
                end
            end
            SQ_SETUP: begin
                if (!scl_s) begin
                    r_d.state = SQ_WAIT_SCL;
                end else if (tmr_last) begin
                    r_d.state = SQ_LET_SDA;
                end
            end
            SQ_LET_SDA: begin
                if (sda_s) begin
                    r_d.state = SQ_IDLE;
                    r_d.done  = 1'b1;
                end
            end
            default: begin
                r_d.state = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: SQ_IDLE, fast: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low = (r_q.state == SQ_GRAB);
    assign sda_drive_low = (r_q.state == SQ_GRAB) || (r_q.state == SQ_WAIT_SCL) ||
                           (r_q.state == SQ_SETUP);
    assign wait_released = (r_q.state == SQ_WAIT_SCL) || (r_q.state == SQ_SETUP) ||
                           (r_q.state == SQ_LET_SDA);
    assign done          = r_q.done;

endmodule

// File: rtl/stop_seq_chk.sv
module stop_seq_chk #(
    parameter int STD_CYC  = 1000,
    parameter int FAST_CYC = 150
) (
    input logic clk,
    input logic rst_n,
    input logic stop_req,
    input logic scl_drive_low,
    input logic sda_drive_low,
    input logic wait_released,
    input logic done,
    input logic scl_sync,
    input logic sda_sync,
    input logic fast_lat
);

    logic        armed_q;
    logic [15:0] hi_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q  <= 1'b0;
            hi_cnt_q <= '0;
        end else begin
            armed_q <= 1'b1;
            if (wait_released && scl_sync) begin
                if (hi_cnt_q != 16'hFFFF) begin
                    hi_cnt_q <= hi_cnt_q + 16'd1;
                end
            end else begin
                hi_cnt_q <= '0;
            end
        end
    end

    // R2
    sda_low_while_grab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> sda_drive_low);

    // R2
    clock_let_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |=> (!scl_drive_low && wait_released));

    // R4
    sda_rise_needs_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(sda_drive_low)) |-> $past(scl_sync));

    // R4
    setup_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $fell(sda_drive_low)) |->
            (int'(hi_cnt_q) >= (fast_lat ? FAST_CYC : STD_CYC)));

    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && wait_released) |-> $stable(fast_lat));

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    done_after_sda_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && done) |-> (!sda_drive_low && !wait_released && $past(sda_sync)));

    // R8
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_released && stop_req) |=> !scl_drive_low);

endmodule

bind i2c_stop_seq stop_seq_chk #(
    .STD_CYC  (STD_CYC),
    .FAST_CYC (FAST_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .scl_drive_low (scl_drive_low),
    .sda_drive_low (sda_drive_low),
    .wait_released (wait_released),
    .done          (done),
    .scl_sync      (scl_s),
    .sda_sync      (sda_s),
    .fast_lat      (r_q.fast)
);

// File: tb/sim_i2c_stop_seq.sv
`timescale 1ns/1ps
module sim_i2c_stop_seq;

    localparam int KHZ    = 10000;
    localparam int STD_L  = (KHZ * 4000 + 999999) / 1000000;
    localparam int FAST_L = (KHZ * 600 + 999999) / 1000000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic fast_mode = 1'b0;
    logic tgt_scl_low = 1'b0;
    logic oth_sda_low = 1'b0;
    logic scl_in;
    logic sda_in;
    logic scl_drive_low;
    logic sda_drive_low;
    logic wait_released;
    logic done;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    assign scl_in = ~scl_drive_low & ~tgt_scl_low;
    assign sda_in = ~sda_drive_low & ~oth_sda_low;

    i2c_stop_seq #(
        .CLK_FREQ_KHZ  (KHZ),
        .STD_SETUP_NS  (4000),
        .FAST_SETUP_NS (600)
    ) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .stop_req      (stop_req),
        .fast_mode     (fast_mode),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .scl_drive_low (scl_drive_low),
        .sda_drive_low (sda_drive_low),
        .wait_released (wait_released),
        .done          (done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int outs();
        return {28'd0, scl_drive_low, sda_drive_low, wait_released, done};
    endfunction

    task automatic run_seq(input bit mode, input int stretch, input int hold,
                           input bit flip, input bit busy, input bit glitch);
        int lim;
        int n;
        string rq;
        lim = mode ? FAST_L : STD_L;
        @(negedge clk);
        chk(outs() == 0, "R1", "idle outputs", outs(), 0);
        tgt_scl_low = (stretch > 0);
        oth_sda_low = (hold > 0);
        stop_req    = 1'b1;
        fast_mode   = mode;
        @(negedge clk);
        stop_req = 1'b0;
        if (flip) fast_mode = ~mode;
        chk(outs() == 4'b1100, "R1", "grab outputs", outs(), 4'b1100);
        @(negedge clk);
        chk(outs() == 4'b0110, "R2", "clock let go", outs(), 4'b0110);
        for (int i = 0; i < stretch; i++) begin
            if (busy && i == 0) begin
                stop_req  = 1'b1;
                fast_mode = ~mode;
            end
            @(negedge clk);
            stop_req = 1'b0;
            if (busy && i == 0) begin
                chk(!scl_drive_low, "R8", "busy request re-grabbed clock", scl_drive_low, 0);
            end
            chk(sda_drive_low && !scl_drive_low, "R3", "sda held while stretched",
                sda_drive_low, 1);
        end
        tgt_scl_low = 1'b0;
        if (glitch) begin
            repeat (4) @(negedge clk);
            chk(sda_drive_low, "R5", "sda before glitch", sda_drive_low, 1);
            tgt_scl_low = 1'b1;
            @(negedge clk);
            chk(sda_drive_low, "R5", "sda during glitch", sda_drive_low, 1);
            tgt_scl_low = 1'b0;
        end
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (sda_drive_low && n < 1000);
        rq = glitch ? "R5" : (flip ? "R6" : (busy ? "R8" : "R4"));
        chk(n == lim + 3, rq, "edges to sda release", n, lim + 3);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk(!done, "R7", "done while sda held low", done, 0);
        end
        oth_sda_low = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!done && n < 50);
        chk(n == 3, "R7", "edges to done", n, 3);
        chk(!wait_released, "R7", "wait_released with done", wait_released, 0);
        @(negedge clk);
        chk(!done, "R7", "done width", done, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (R1-run): got %0d cycles expected completion", 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(outs() == 0, "R1", "outputs in reset", outs(), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 0, "R1", "outputs after reset", outs(), 0);
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 5; s++) begin
                for (int h = 0; h < 3; h++) begin
                    run_seq(m[0], s * s, h * 2, s == 2, s == 3, s == 4);
                end
            end
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule